// File: doc/BRIEF.md
# Serial Input Sampler With Fractional Delay

This block sits between a set of serial input streams and the data memory of a time-slot switch. It runs from a fast clock that ticks four times per serial bit, aligns itself to the frame pulse, and recovers one byte per channel per stream. Each stream has a 5-bit timing field. A global mode bit chooses how the field is read. In one mode it is a delay in quarter-bit steps. In the other it sets a whole-bit delay plus a sampling quarter inside the bit.

The frame pulse is active low and can be single or double width. A separate select moves the frame boundary by half a pulse width, which models the choice of clock edge. After the first boundary, every stream has its own lane. Each lane emits a one-cycle strobe with the channel index and the assembled byte each time a channel completes. The lane index is the stream number. Frame length is set by `CHANNELS` channels of 8 bits, 4 ticks each.

Top module: `ser_in_sampler`

## Requirements
- R1: After reset, and until the first frame boundary has been reached, every `vld_o` bit stays low and `ch_o` and `byte_o` read zero.
- R2: The clock edge at which `fp_i` is first sampled low is E0. With H = FP_TICKS/2, the boundary edge is E0 plus an offset: H when `fp_wide_i`=0 and `edge_sel_i`=0; 2H when exactly one of them is 1; 3H when both are 1. The data value sampled at the boundary edge is line tick 0, and each following edge is the next line tick.
- R3: With `samp_mode_i`=0, stream s samples bit i of the frame at line tick 4i + 4*dly[4:2] + dly[1:0] + 3.
- R4: With `samp_mode_i`=1, stream s samples bit i of the frame at line tick 4i + 4*dly[4:2] + 3 - dly[1:0].
- R5: Bits are assembled most significant first: the first sampled bit of a channel appears in `byte_o[s][7]`, and the eighth in bit 0.
- R6: `vld_o[s]` is high for exactly one clock, in the cycle after the edge that samples the eighth bit of a channel. In that cycle `ch_o[s]` holds the channel index. `ch_o[s]` changes only together with a strobe.
- R7: Channel indices count modulo CHANNELS, so the last channel (511 by default) is followed by 0. Bits of the last channel that are sampled after the next boundary are still credited to that last channel.
- R8: Lanes are independent. Each lane uses only its own `dly_i` field, and lane s reports stream s.
- R9: A later frame pulse re-aligns the frame timer to the boundary that R2 gives for the new pulse. Once the first boundary has been reached, strobes keep occurring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four ticks per serial bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, active low |
| fp_wide_i | input | 1 | 1 selects the double-width pulse |
| edge_sel_i | input | 1 | 1 moves the boundary by half a pulse width (alternate clock edge) |
| samp_mode_i | input | 1 | 0: fractional delay, 1: sampling-point select |
| sd_i | input | N_STREAMS | Serial data, one line per stream |
| dly_i | input | N_STREAMS x 5 | Per-stream timing field |
| vld_o | output | N_STREAMS | Per-lane byte-valid strobe |
| ch_o | output | N_STREAMS x log2(CHANNELS) | Channel index of the byte on each lane |
| byte_o | output | N_STREAMS x 8 | Recovered byte on each lane |

## Verification
The bench drives each stream so that the true bit is present only on the single quarter-tick where that stream should sample it, and the complement is present on the other three quarters. A sampling point one quarter early or late therefore yields inverted bits.

Configurations are walked through:
- all-zero fields;
- an ascending per-stream ramp;
- scattered values up to 31 in both modes;
- every combination of pulse width and edge select.

These tell apart the two field interpretations, the whole-bit and quarter-bit parts of the field, and the four boundary offsets. They also show whether lanes take their timing from one another.

A full-frame run shows the last channel's bits being collected across the boundary and the index wrapping to zero. A second frame pulse with a different width confirms that the timer re-aligns.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int TICKS_PER_BIT = 4;
  localparam int BITS_PER_CH   = 8;

  typedef logic [4:0] dly_t;

  // boundary distance, in ticks, from the first low sample of the frame pulse
  function automatic int fp_ofs(int fp_ticks, logic wide, logic esel);
    int o;
    o = wide ? fp_ticks : fp_ticks / 2;
    if (esel) o = o + fp_ticks / 2;
    return o;
  endfunction
endpackage

// File: rtl/sis_frame_timer.sv
module sis_frame_timer #(
  parameter int FP_TICKS = 16,
  parameter int FTW      = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fp_i,
  input  logic           fp_wide_i,
  input  logic           edge_sel_i,
  output logic [FTW-1:0] ftick_o,
  output logic           sync_o
);
  import sis_pkg::*;

  localparam int CNTW = $clog2(2 * FP_TICKS);

  logic            fp_d;
  logic            fall;
  logic            armed_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] ld;
  logic            load;

  assign fall = fp_d & ~fp_i;
  // countdown ends one edge early so that ftick reads 0 at the boundary edge
  assign ld   = CNTW'(fp_ofs(FP_TICKS, fp_wide_i, edge_sel_i) - 2);
  assign load = armed_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_d <= 1'b1;
    else         fp_d <= fp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fall) begin
      armed_q <= 1'b1;
      cnt_q   <= ld;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftick_o <= '0;
      sync_o  <= 1'b0;
    end else begin
      ftick_o <= load ? '0 : ftick_o + 1'b1;
      sync_o  <= sync_o | load;
    end
  end

  p_tick_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> ftick_o == FTW'($past(ftick_o) + 1'b1));

  p_sync_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> sync_o);

  p_arm_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> armed_q);
endmodule

// File: rtl/sis_offset_dec.sv
module sis_offset_dec
  import sis_pkg::*;
(
  input  logic       samp_mode_i,
  input  dly_t       dly_i,
  output logic [5:0] ofs_o
);
  logic [5:0] whole;
  logic [5:0] frac;

  assign whole = {1'b0, dly_i[4:2], 2'b00};
  // default phase is the last quarter of the bit; mode picks the direction of the quarter step
  assign frac  = samp_mode_i ? 6'(3 - dly_i[1:0]) : 6'(3 + dly_i[1:0]);
  assign ofs_o = whole + frac;
endmodule

// File: rtl/sis_lane.sv
module sis_lane
  import sis_pkg::*;
#(
  parameter int FTW = 14,
  parameter int CHW = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [FTW-1:0] ftick_i,
  input  logic           sync_i,
  input  logic           samp_mode_i,
  input  dly_t           dly_i,
  input  logic           sd_i,
  output logic           vld_o,
  output logic [CHW-1:0] ch_o,
  output logic [7:0]     byte_o
);
  logic [5:0]     ofs;
  logic [FTW-1:0] rel;
  logic [6:0]     sh_q;
  logic           hit;
  logic           last;

  sis_offset_dec u_dec (
    .samp_mode_i(samp_mode_i),
    .dly_i      (dly_i),
    .ofs_o      (ofs)
  );

  assign rel  = ftick_i - FTW'(ofs);
  assign hit  = sync_i & (rel[1:0] == 2'b00);
  assign last = rel[4:2] == 3'(BITS_PER_CH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      vld_o  <= 1'b0;
      ch_o   <= '0;
      byte_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (hit) begin
        sh_q <= {sh_q[5:0], sd_i};
        if (last) begin
          vld_o  <= 1'b1;
          byte_o <= {sh_q, sd_i};
          ch_o   <= rel[FTW-1:5];
        end
      end
    end
  end

  p_vld_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  p_vld_sync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> sync_i);

  p_ch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ch_o) |-> vld_o);
endmodule

// File: rtl/ser_in_sampler.sv
module ser_in_sampler
  import sis_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int CHANNELS  = 512,
  parameter int FP_TICKS  = 16,
  localparam int CHW      = $clog2(CHANNELS),
  localparam int FTW      = CHW + $clog2(BITS_PER_CH) + $clog2(TICKS_PER_BIT)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            fp_i,
  input  logic                            fp_wide_i,
  input  logic                            edge_sel_i,
  input  logic                            samp_mode_i,
  input  logic [N_STREAMS-1:0]            sd_i,
  input  logic [N_STREAMS-1:0][4:0]       dly_i,
  output logic [N_STREAMS-1:0]            vld_o,
  output logic [N_STREAMS-1:0][CHW-1:0]   ch_o,
  output logic [N_STREAMS-1:0][7:0]       byte_o
);
  logic [FTW-1:0] ftick;
  logic           sync;

  sis_frame_timer #(
    .FP_TICKS(FP_TICKS),
    .FTW     (FTW)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fp_i      (fp_i),
    .fp_wide_i (fp_wide_i),
    .edge_sel_i(edge_sel_i),
    .ftick_o   (ftick),
    .sync_o    (sync)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
    sis_lane #(
      .FTW(FTW),
      .CHW(CHW)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ftick_i    (ftick),
      .sync_i     (sync),
      .samp_mode_i(samp_mode_i),
      .dly_i      (dly_i[s]),
      .sd_i       (sd_i[s]),
      .vld_o      (vld_o[s]),
      .ch_o       (ch_o[s]),
      .byte_o     (byte_o[s])
    );
  end

  p_quiet_unsynced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync |=> vld_o == '0);
endmodule

// File: tb/sim_ser_in_sampler.sv
module sim_ser_in_sampler;
  localparam int NS  = 8;
  localparam int CH  = 512;
  localparam int FPT = 16;
  localparam int H   = FPT / 2;
  localparam int FT  = CH * 32;

  typedef struct packed {
    logic               mode;
    logic               wide;
    logic               esel;
    logic [NS-1:0][4:0] dly;
    logic [15:0]        nt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}, 16'd300},
    '{1'b0, 1'b0, 1'b0, {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 16'd300},
    '{1'b0, 1'b1, 1'b0, {5'd5, 5'd30, 5'd9, 5'd17, 5'd2, 5'd1, 5'd3, 5'd31}, 16'd300},
    '{1'b1, 1'b0, 1'b1, {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 16'd300},
    '{1'b1, 1'b1, 1'b1, {5'd0, 5'd1, 5'd2, 5'd3, 5'd10, 5'd19, 5'd28, 5'd31}, 16'd300},
    '{1'b0, 1'b0, 1'b1, {5'd12, 5'd23, 5'd8, 5'd15, 5'd26, 5'd4, 5'd11, 5'd30}, 16'd300}
  };

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 fp_i = 1'b1;
  logic                 fp_wide_i = 1'b0;
  logic                 edge_sel_i = 1'b0;
  logic                 samp_mode_i = 1'b0;
  logic [NS-1:0]        sd_i = '0;
  logic [NS-1:0][4:0]   dly_i = '0;
  logic [NS-1:0]        vld_o;
  logic [NS-1:0][8:0]   ch_o;
  logic [NS-1:0][7:0]   byte_o;

  int    errors = 0;
  int    checks = 0;
  int    ln = 0;
  int    fp_left = 0;
  bit    track = 0;
  bit    fresh = 1;
  bit    seen_last = 0;
  bit    wrap_ok = 0;
  string tag = "R3";

  always #10 clk = ~clk;

  ser_in_sampler #(.N_STREAMS(NS), .CHANNELS(CH), .FP_TICKS(FPT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp_i), .fp_wide_i(fp_wide_i),
    .edge_sel_i(edge_sel_i), .samp_mode_i(samp_mode_i), .sd_i(sd_i),
    .dly_i(dly_i), .vld_o(vld_o), .ch_o(ch_o), .byte_o(byte_o)
  );

  function automatic int md(int a);
    return ((a % FT) + FT) % FT;
  endfunction

  function automatic int soff(int s);
    int w, q;
    w = int'(dly_i[s][4:2]);
    q = int'(dly_i[s][1:0]);
    return 4 * w + (samp_mode_i ? 3 - q : 3 + q);
  endfunction

  function automatic int boff();
    return (fp_wide_i ? FPT : H) + (edge_sel_i ? H : 0);
  endfunction

  function automatic logic [7:0] pat(int c, int s);
    return 8'((c * 29 + s * 83 + 90) ^ (c >> 2));
  endfunction

  // true bit only on the expected sample quarter, complement elsewhere
  function automatic logic lbit(int s, int t);
    int r, bi;
    logic [7:0] b;
    r  = md(t - soff(s));
    bi = r >> 2;
    b  = pat(bi >> 3, s);
    return (r % 4 == 0) ? b[7 - (bi % 8)] : ~b[7 - (bi % 8)];
  endfunction

  task automatic chk(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h (line tick %0d)", t, what, act, exp, ln);
    end
  endtask

  task automatic check_prev(int p);
    int r, c;
    bit ev;
    if (!track) return;
    if (p < 0) begin
      if (fresh) chk(vld_o == '0, "R1", "strobe before first boundary", int'(vld_o), 0);
      return;
    end
    for (int s = 0; s < NS; s++) begin
      r  = md(p - soff(s));
      ev = (r % 4 == 0) && (((r >> 2) % 8) == 7);
      if (ev || vld_o[s]) begin
        chk(vld_o[s] == ev, tag, $sformatf("strobe lane %0d", s), int'(vld_o[s]), int'(ev));
        if (ev) begin
          c = r >> 5;
          chk(int'(ch_o[s]) == c, tag, $sformatf("channel lane %0d", s), int'(ch_o[s]), c);
          if (!(c == CH - 1 && p < 64))
            chk(byte_o[s] == pat(c, s), tag, $sformatf("byte lane %0d ch %0d", s, c),
                int'(byte_o[s]), int'(pat(c, s)));
          if (s == 0) begin
            if (c == CH - 1 && p >= 64) seen_last = 1;
            else if (c == 0 && seen_last) begin
              wrap_ok   = 1;
              seen_last = 0;
            end
          end
        end
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_prev(ln - 1);
    for (int s = 0; s < NS; s++) sd_i[s] = lbit(s, ln);
    if (fp_left > 0) begin
      fp_i = 1'b0;
      fp_left--;
    end else begin
      fp_i = 1'b1;
    end
    @(posedge clk);
    ln++;
  endtask

  task automatic send_fp();
    ln      = -boff();
    fp_left = fp_wide_i ? 2 * FPT : FPT;
    track   = 1;
  endtask

  task automatic do_reset();
    track = 0;
    fresh = 1;
    @(negedge clk);
    rst_ni = 1'b0;
    fp_i   = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit any;
    do_reset();
    @(negedge clk);
    // R1: reset values at the ports
    chk(vld_o == '0, "R1", "reset strobes", int'(vld_o), 0);
    chk(ch_o == '0, "R1", "reset channel", int'(ch_o[0]), 0);
    chk(byte_o == '0, "R1", "reset byte", int'(byte_o[0]), 0);
    any = 0;
    repeat (40) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) sd_i[s] = ~sd_i[s];
      if (vld_o != '0) any = 1;
    end
    chk(!any, "R1", "strobe without frame pulse", int'(any), 0);

    // table walk: modes, pulse shapes, per-stream fields
    for (int v = 0; v < 6; v++) begin
      do_reset();
      samp_mode_i = VECS[v].mode;
      fp_wide_i   = VECS[v].wide;
      edge_sel_i  = VECS[v].esel;
      dly_i       = VECS[v].dly;
      tag = VECS[v].mode ? "R4 R2 R5 R6 R8" : "R3 R2 R5 R6 R8";
      send_fp();
      repeat (int'(VECS[v].nt)) tick();
    end

    // R7: full frame, last channel crossing the boundary, index wrap
    do_reset();
    samp_mode_i = 1'b0;
    fp_wide_i   = 1'b0;
    edge_sel_i  = 1'b0;
    dly_i       = {5'd31, 5'd0, 5'd13, 5'd6, 5'd27, 5'd1, 5'd20, 5'd29};
    tag         = "R7 R3 R5 R6";
    seen_last   = 0;
    wrap_ok     = 0;
    send_fp();
    repeat (FT + 300) tick();
    chk(wrap_ok, "R7", "last channel followed by channel 0", int'(wrap_ok), 1);

    // R9: new pulse of the other width re-aligns the running timer
    repeat (77) tick();
    fresh       = 0;
    fp_wide_i   = 1'b1;
    samp_mode_i = 1'b1;
    tag         = "R9 R2 R4 R6";
    send_fp();
    repeat (300) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule